// File: doc/BRIEF.md
# Per-Port Credit Rate Meter

This block limits how fast one port may send. It holds a byte credit, counted in 8-byte units. Each departing frame spends credit equal to its length, rounded up to whole units. On a fixed cadence of millisecond ticks the credit is topped up by a programmed amount, and it never rises above a programmed burst ceiling. This gives an average departure rate measured over a chosen window, with a cap on how much can leave back-to-back.

All settings arrive together as one packed 64-bit word, sampled on a load strobe. Loading a word fills the credit to the new ceiling and restarts the window. A frame that lacks credit is simply not granted. It waits in its queue and is never discarded, so the requester keeps asking until refills cover it. The live credit level is an output, so neighbouring logic can compare it against its own thresholds.

Top module: `credit_meter`

## Requirements
- R1: After reset the credit level is 0 and every stored setting is 0, so no refill happens until a word is loaded.
- R2: When cfgLoad is high, cfgWord is sampled as follows: bits 39:32 give the window length in ms ticks, bits 31:16 give the credit ceiling in 8-byte units, and bits 15:0 give the refill amount in 8-byte units. On the next cycle the credit equals the new ceiling and the tick count restarts at zero.
- R3: grant is a same-cycle combinational output. It is high exactly when reqValid is high, cfgLoad is low, and the credit is at least ceil(reqLen/8) units. A zero-length request needs 0 units.
- R4: On a granted cycle, the credit after the clock edge is reduced by ceil(reqLen/8) units.
- R5: A request that the credit does not cover is not granted. Without a tick or load, the credit stays unchanged, and the request may be repeated until it is covered.
- R6: With a window of N>0, the credit grows by the refill amount on every Nth msTick counted since the last load, and at no other time.
- R7: The credit never exceeds the loaded ceiling. A refill that would pass it stops at the ceiling.
- R8: A window value of 0 disables refill, whatever the number of ticks.
- R9: When a grant and a refill fall on the same cycle, the frame's units are subtracted first, then the refill is added, then the result is capped at the ceiling.
- R10: A request in the same cycle as cfgLoad is ignored. It is not granted, and the credit becomes exactly the new ceiling.
- R11: cfgWord bits 63:40 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | Strobe that samples cfgWord |
| cfgWord | input | 64 | Packed window, ceiling and refill settings |
| msTick | input | 1 | One-cycle pulse per millisecond |
| reqValid | input | 1 | A frame asks to depart this cycle |
| reqLen | input | 16 | Frame length in bytes |
| grant | output | 1 | Frame may depart; its credit is spent |
| creditLevel | output | 16 | Current credit in 8-byte units |

## Verification
The bench targets the following corner cases:
- Lengths that are not multiples of 8. A meter that truncated instead of rounding up would under-charge these frames.
- A request exactly equal to the remaining credit. An off-by-one comparison would wrongly deny it.
- Refills that reach past the ceiling. Missing saturation would let the credit climb without bound.
- A grant and a refill in the same cycle. Misordering the two could deny a covered frame or lose the refill.
- The tick that closes a window. A counter that wraps one tick early or late shifts the average rate.
- A window of zero, which must never refill.
- A load colliding with a request, which must leave the credit exactly at the new ceiling.

// File: rtl/credit_meter_pkg.sv
package credit_meter_pkg;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic load;     // take new ceiling/refill and reset credit
    logic consume;  // subtract the pending frame's units
    logic refill;   // add the per-window amount
  } meterCtrl_t;

endpackage

// File: rtl/credit_meter_units.sv
// Rounds a byte length up to whole credit units.
module credit_meter_units #(
  parameter int LEN_W      = 16,
  parameter int UNIT_SHIFT = 3,
  localparam int UNIT_W    = LEN_W - UNIT_SHIFT + 1
) (
  input  logic [LEN_W-1:0]  lenBytes,
  output logic [UNIT_W-1:0] lenUnits
);
  localparam int WIDE_W = LEN_W + 1;
  localparam logic [WIDE_W-1:0] ROUND_ADD = WIDE_W'((1 << UNIT_SHIFT) - 1);

  logic [WIDE_W-1:0] padded;
  logic [WIDE_W-1:0] shifted;

  always_comb begin
    padded   = {1'b0, lenBytes} + ROUND_ADD;
    shifted  = padded >> UNIT_SHIFT;
    lenUnits = shifted[UNIT_W-1:0];
  end
endmodule

// File: rtl/credit_meter_ctrl.sv
// Window counter and grant/refill strobe generation.
module credit_meter_ctrl
  import credit_meter_pkg::*;
#(
  parameter int INTERVAL_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgLoad,
  input  logic [INTERVAL_W-1:0] cfgInterval,
  input  logic                  msTick,
  input  logic                  reqValid,
  input  logic                  covers,
  output meterCtrl_t            ctrl,
  output logic                  grant
);
  logic [INTERVAL_W-1:0] intervalReg;
  logic [INTERVAL_W-1:0] tickCnt;
  logic                  windowOn;
  logic                  windowEnd;

  always_comb begin
    windowOn     = (intervalReg != '0);
    windowEnd    = windowOn && (tickCnt == INTERVAL_W'(intervalReg - 1'b1));
    ctrl.load    = cfgLoad;
    ctrl.consume = reqValid && !cfgLoad && covers;
    ctrl.refill  = !cfgLoad && msTick && windowEnd;
    grant        = ctrl.consume;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalReg <= '0;
      tickCnt     <= '0;
    end else if (cfgLoad) begin
      intervalReg <= cfgInterval;
      tickCnt     <= '0;
    end else if (msTick && windowOn) begin
      tickCnt <= windowEnd ? '0 : INTERVAL_W'(tickCnt + 1'b1);
    end
  end
endmodule

// File: rtl/credit_meter_dp.sv
// Credit register, coverage compare, spend/refill/saturate arithmetic.
module credit_meter_dp
  import credit_meter_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int CREDIT_W   = 16,
  parameter int UNIT_SHIFT = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  meterCtrl_t          ctrl,
  input  logic [CREDIT_W-1:0] cfgBurst,
  input  logic [CREDIT_W-1:0] cfgRefill,
  input  logic [LEN_W-1:0]    reqLen,
  output logic                covers,
  output logic [CREDIT_W-1:0] creditLevel
);
  localparam int UNIT_W = LEN_W - UNIT_SHIFT + 1;
  localparam int MAX_W  = (CREDIT_W > UNIT_W) ? CREDIT_W : UNIT_W;
  localparam int CMP_W  = MAX_W + 1;

  logic [CREDIT_W-1:0] creditReg;
  logic [CREDIT_W-1:0] burstReg;
  logic [CREDIT_W-1:0] refillReg;
  logic [UNIT_W-1:0]   reqUnits;
  logic [CMP_W-1:0]    afterSpend;
  logic [CMP_W-1:0]    afterFill;
  logic [CMP_W-1:0]    ceilingWide;
  logic [CREDIT_W-1:0] creditNext;

  credit_meter_units #(
    .LEN_W      (LEN_W),
    .UNIT_SHIFT (UNIT_SHIFT)
  ) units_i (
    .lenBytes (reqLen),
    .lenUnits (reqUnits)
  );

  always_comb begin
    covers      = CMP_W'(creditReg) >= CMP_W'(reqUnits);
    afterSpend  = CMP_W'(creditReg) - (ctrl.consume ? CMP_W'(reqUnits) : '0);
    afterFill   = afterSpend + (ctrl.refill ? CMP_W'(refillReg) : '0);
    ceilingWide = CMP_W'(burstReg);
    if (afterFill > ceilingWide) creditNext = burstReg;
    else                         creditNext = afterFill[CREDIT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      creditReg <= '0;
      burstReg  <= '0;
      refillReg <= '0;
    end else if (ctrl.load) begin
      creditReg <= cfgBurst;
      burstReg  <= cfgBurst;
      refillReg <= cfgRefill;
    end else begin
      creditReg <= creditNext;
    end
  end

  assign creditLevel = creditReg;
endmodule

// File: rtl/credit_meter.sv
// Top: slices the settings word and joins control with datapath.
module credit_meter
  import credit_meter_pkg::*;
#(
  parameter int WORD_W     = 64,
  parameter int LEN_W      = 16,
  parameter int CREDIT_W   = 16,
  parameter int INTERVAL_W = 8,
  parameter int UNIT_SHIFT = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgLoad,
  input  logic [WORD_W-1:0]   cfgWord,
  input  logic                msTick,
  input  logic                reqValid,
  input  logic [LEN_W-1:0]    reqLen,
  output logic                grant,
  output logic [CREDIT_W-1:0] creditLevel
);
  localparam int REFILL_LSB   = 0;
  localparam int BURST_LSB    = CREDIT_W;
  localparam int INTERVAL_LSB = 2 * CREDIT_W;
  localparam int USED_W       = INTERVAL_LSB + INTERVAL_W;

  meterCtrl_t ctrl;
  logic       covers;
  logic       unusedReserved;

  assign unusedReserved = ^cfgWord[WORD_W-1:USED_W];

  credit_meter_ctrl #(
    .INTERVAL_W (INTERVAL_W)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .cfgLoad     (cfgLoad),
    .cfgInterval (cfgWord[INTERVAL_LSB +: INTERVAL_W]),
    .msTick      (msTick),
    .reqValid    (reqValid),
    .covers      (covers),
    .ctrl        (ctrl),
    .grant       (grant)
  );

  credit_meter_dp #(
    .LEN_W      (LEN_W),
    .CREDIT_W   (CREDIT_W),
    .UNIT_SHIFT (UNIT_SHIFT)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .cfgBurst    (cfgWord[BURST_LSB +: CREDIT_W]),
    .cfgRefill   (cfgWord[REFILL_LSB +: CREDIT_W]),
    .reqLen      (reqLen),
    .covers      (covers),
    .creditLevel (creditLevel)
  );
endmodule

// File: rtl/credit_meter_chk.sv
module credit_meter_chk #(
  parameter int WORD_W   = 64,
  parameter int LEN_W    = 16,
  parameter int CREDIT_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgLoad,
  input logic [WORD_W-1:0]   cfgWord,
  input logic                msTick,
  input logic                reqValid,
  input logic [LEN_W-1:0]    reqLen,
  input logic                grant,
  input logic [CREDIT_W-1:0] creditLevel
);
  logic [CREDIT_W-1:0] seenCeiling;
  logic                unusedLen;

  assign unusedLen = ^reqLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        seenCeiling <= '0;
    else if (cfgLoad) seenCeiling <= cfgWord[CREDIT_W +: CREDIT_W];
  end

  AST_LOAD_SETS_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> creditLevel == $past(cfgWord[CREDIT_W +: CREDIT_W])); // R2

  AST_LOAD_BLOCKS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |-> !grant); // R10

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> reqValid); // R3

  AST_NO_TICK_NO_GAIN: assert property (@(posedge clk) disable iff (!rstN)
    (!msTick && !cfgLoad) |=> creditLevel <= $past(creditLevel)); // R6

  AST_DENY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !grant && !msTick && !cfgLoad) |=> $stable(creditLevel)); // R5

  AST_CREDIT_CAPPED: assert property (@(posedge clk) disable iff (!rstN)
    creditLevel <= seenCeiling); // R7
endmodule

bind credit_meter credit_meter_chk #(
  .WORD_W   (WORD_W),
  .LEN_W    (LEN_W),
  .CREDIT_W (CREDIT_W)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .cfgLoad     (cfgLoad),
  .cfgWord     (cfgWord),
  .msTick      (msTick),
  .reqValid    (reqValid),
  .reqLen      (reqLen),
  .grant       (grant),
  .creditLevel (creditLevel)
);

// File: tb/credit_meter_tb_top.sv
`timescale 1ns/1ps
module credit_meter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [63:0] cfgWord = '0;
  logic        msTick = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqLen = '0;
  logic        grant;
  logic [15:0] creditLevel;

  always #2 clk = ~clk;

  credit_meter dut_i (
    .clk (clk), .rstN (rstN), .cfgLoad (cfgLoad), .cfgWord (cfgWord),
    .msTick (msTick), .reqValid (reqValid), .reqLen (reqLen),
    .grant (grant), .creditLevel (creditLevel)
  );

  typedef struct {
    logic        expGrant;
    logic [15:0] expCredit;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;

  // reference state
  int mCredit = 0, mBurst = 0, mFill = 0, mWin = 0, mCnt = 0;

  task automatic check(string tag, int act, int exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkWord(int win, int burst, int fill, int rsv);
    return {24'(rsv), 8'(win), 16'(burst), 16'(fill)};
  endfunction

  // driver: applies one cycle of stimulus and pushes the expectation
  task automatic step(bit ld, logic [63:0] w, bit tk, bit rv, int len, string tag);
    item_t it;
    int units, c;
    bit g, fill;
    @(negedge clk);
    cfgLoad = ld; cfgWord = w; msTick = tk; reqValid = rv; reqLen = 16'(len);
    units = (len + 7) / 8;
    g = rv && !ld && (mCredit >= units);
    if (ld) begin
      mWin = int'(w[39:32]); mBurst = int'(w[31:16]); mFill = int'(w[15:0]);
      mCredit = mBurst; mCnt = 0;
    end else begin
      c = mCredit - (g ? units : 0);
      fill = tk && mWin != 0 && mCnt == mWin - 1;
      if (tk && mWin != 0) mCnt = fill ? 0 : mCnt + 1;
      if (fill) c = c + mFill;
      if (c > mBurst) c = mBurst;
      mCredit = c;
    end
    it.expGrant = g; it.expCredit = 16'(mCredit); it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, tag);
  endtask

  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) step(0, '0, 1, 0, 0, tag);
  endtask

  // monitor: pops and compares as results appear
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() != 0) begin
        it = q.pop_front();
        check(it.tag, int'(grant), int'(it.expGrant), "grant");
        @(posedge clk);
        #1;
        check(it.tag, int'(creditLevel), int'(it.expCredit), "credit");
      end
    end
  end

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL R1 watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, nothing granted, ticks do nothing
    idle(1, "R1");
    step(0, '0, 0, 1, 8, "R1");
    ticks(3, "R1");
    // R2 / R11: load with reserved bits set
    step(1, mkWord(3, 100, 10, 24'hABCDEF), 0, 0, 0, "R11");
    // R3 / R4: rounding up of odd lengths
    step(0, '0, 0, 1, 17, "R4");
    step(0, '0, 0, 1, 8, "R4");
    step(0, '0, 0, 1, 0, "R3");
    // R5: uncovered request waits, repeated
    step(0, '0, 0, 1, 800, "R5");
    step(0, '0, 0, 1, 800, "R5");
    // R7: refill capped at ceiling on third tick
    ticks(3, "R7");
    // drain then R6 window cadence
    step(0, '0, 0, 1, 760, "R4");
    ticks(2, "R6");
    idle(1, "R6");
    ticks(1, "R6");
    ticks(3, "R6");
    // R9: grant and refill same cycle
    ticks(2, "R9");
    step(0, '0, 1, 1, 200, "R9");
    // R3: exact-boundary request
    step(0, '0, 0, 1, 8 * mCredit, "R3");
    step(0, '0, 0, 1, 1, "R5");
    // R10: load colliding with request
    step(1, mkWord(0, 50, 20, 0), 0, 1, 8, "R10");
    step(0, '0, 0, 1, 320, "R4");
    // R8: window zero never refills
    ticks(10, "R8");
    // R2: reload restarts window count
    step(1, mkWord(2, 40, 5, 0), 0, 0, 0, "R2");
    step(0, '0, 0, 1, 300, "R2");
    ticks(1, "R2");
    step(1, mkWord(2, 40, 5, 0), 0, 0, 0, "R2");
    step(0, '0, 0, 1, 300, "R2");
    ticks(1, "R6");
    ticks(1, "R6");
    idle(3, "R1");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule